// File: doc/BRIEF.md
# Stream identifier span matcher

This block decides, per transaction, whether the stream identifier that came with it belongs to the set an event counter should count. It holds a programmed identifier pattern and a mode bit. In exact mode every identifier bit has to equal the pattern. In span mode the pattern also says how many low identifier bits are ignored. The lowest zero bit of the pattern marks the top of the ignored field. That bit and every bit below it are treated as don't-care, and every bit above it has to match.

Software loads the pattern and the mode through a small write port. One select value loads the pattern word. The other loads a per-counter event-type word, and only the mode bit is taken from that word. Identifiers arrive with a valid strobe. A registered verdict leaves the block one clock later, together with a valid flag.

Top module: `sid_span_filter`

## Requirements
- R1: After reset the pattern is all ones and span mode is on, so every identifier matches; matchValid and matchHit are 0 until the first identifier is presented.
- R2: matchValid is high exactly in the cycle after a cycle with sidValid high, and matchHit is 0 whenever matchValid is 0.
- R3: With span mode off, an identifier matches only when all SID_W bits equal the pattern.
- R4: With span mode on and the lowest zero bit of the pattern at position Y-1, identifier bits Y-1 down to 0 are ignored and bits Y and above must equal the pattern; pattern 0x42 matches 0x42 and 0x43 and rejects 0x40, 0x41 and 0x44.
- R5: With span mode on and pattern bit 0 equal to 0, only identifier bit 0 is ignored.
- R6: With span mode on and a pattern that has no zero bit, or whose only zero bit is the top bit, every identifier matches.
- R7: A write with cfgWrEn=1 and cfgSel=0 loads the pattern from cfgData[SID_W-1:0]. A write with cfgSel=1 loads span mode from cfgData bit 29 (the event-type word, whose event number sits in bits 15:0), and all other bits of that word have no effect on matching. With cfgWrEn=0, nothing changes.
- R8: An identifier presented in the same cycle as a configuration write is judged against the settings from before that write; identifiers from the next cycle on use the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the pattern word, 1 selects the event-type word |
| cfgData | input | 32 | Configuration write data |
| sidValid | input | 1 | Identifier valid strobe |
| sidIn | input | SID_W | Incoming stream identifier |
| matchValid | output | 1 | Verdict valid, one cycle after sidValid |
| matchHit | output | 1 | Registered match verdict |

## Verification
The in-line assertions check on every cycle that the verdict keeps its one-cycle pipeline, that a hit never appears without its valid flag, and that the stored pattern changes only on a pattern write. They also check two fixed relations: in exact mode the verdict equals plain identifier equality, and an all-ones span setting accepts every identifier. The bench scenarios alone show the span field width derived from the lowest zero bit, including the boundary patterns with bit 0 clear or only the top bit clear. Only they show that the unused bits of the event-type word are ignored and that a write and an identifier in the same cycle resolve in the stated order.

// File: rtl/sidf_pkg.sv
package sidf_pkg;
  localparam int CFG_W = 32;

  typedef struct packed {
    logic loadPattern;
    logic loadSpan;
    logic sample;
  } sidfStrobe_t;
endpackage

// File: rtl/sidf_ctrl.sv
module sidf_ctrl
  import sidf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic        sidValid,
  output sidfStrobe_t strobe,
  output logic        validQ
);
  always_comb begin
    strobe.loadPattern = cfgWrEn && !cfgSel;
    strobe.loadSpan    = cfgWrEn && cfgSel;
    strobe.sample      = sidValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= sidValid;
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    sidValid |=> validQ); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !sidValid |=> !validQ); // R2
endmodule

// File: rtl/sidf_datapath.sv
module sidf_datapath
  import sidf_pkg::*;
#(
  parameter int SID_W    = 32,
  parameter int SPAN_POS = 29
) (
  input  logic             clk,
  input  logic             rstN,
  input  sidfStrobe_t      strobe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [SID_W-1:0] sidIn,
  output logic             hitQ
);
  localparam logic [SID_W-1:0] PAT_RESET = {SID_W{1'b1}};

  logic [SID_W-1:0] patternQ;
  logic             spanQ;
  logic [SID_W-1:0] ignoreMask;
  logic             hitComb;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      patternQ <= PAT_RESET;
      spanQ    <= 1'b1;
    end else begin
      if (strobe.loadPattern) patternQ <= cfgData[SID_W-1:0];
      if (strobe.loadSpan)    spanQ    <= cfgData[SPAN_POS];
    end
  end

  // priority scan: a bit is ignored while every bit below it is one,
  // which covers the lowest zero bit itself
  always_comb begin
    logic run;
    run = spanQ;
    for (int i = 0; i < SID_W; i++) begin
      ignoreMask[i] = run;
      run = run & patternQ[i];
    end
  end

  assign hitComb = ~|((sidIn ^ patternQ) & ~ignoreMask);

  always_ff @(posedge clk) begin
    if (!rstN) hitQ <= 1'b0;
    else       hitQ <= strobe.sample & hitComb;
  end

  AST_PATTERN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadPattern |=> $stable(patternQ)); // R7
  AST_EXACT_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !spanQ) |=> (hitQ == ($past(sidIn) == $past(patternQ)))); // R3
  AST_OPEN_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && spanQ && (&patternQ)) |=> hitQ); // R6
  AST_HIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.sample |=> !hitQ); // R2
endmodule

// File: rtl/sid_span_filter.sv
module sid_span_filter
  import sidf_pkg::*;
#(
  parameter int SID_W    = 32,
  parameter int SPAN_POS = 29
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [31:0]      cfgData,
  input  logic             sidValid,
  input  logic [SID_W-1:0] sidIn,
  output logic             matchValid,
  output logic             matchHit
);
  sidfStrobe_t strobe;

  sidf_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .sidValid (sidValid),
    .strobe   (strobe),
    .validQ   (matchValid)
  );

  sidf_datapath #(.SID_W(SID_W), .SPAN_POS(SPAN_POS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgData (cfgData),
    .sidIn   (sidIn),
    .hitQ    (matchHit)
  );

  AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |-> matchValid); // R2
endmodule

// File: tb/sid_span_filter_tb_top.sv
module sid_span_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        sidValid = 1'b0;
  logic [31:0] sidIn = '0;
  logic        matchValid;
  logic        matchHit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mPat = 32'hFFFF_FFFF;
  logic        mSpan = 1'b1;

  always #10 clk = ~clk;

  sid_span_filter dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .sidValid(sidValid), .sidIn(sidIn),
    .matchValid(matchValid), .matchHit(matchHit)
  );

  function automatic logic model(logic [31:0] pat, logic span, logic [31:0] id);
    logic [31:0] dc;
    dc = span ? (pat ^ (pat + 32'd1)) : 32'd0;
    return ((id ^ pat) & ~dc) == 32'd0;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(logic sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgData = 32'hA5A5_5A5A;
    if (sel) mSpan = data[29]; else mPat = data;
  endtask

  task automatic probe(string req, logic [31:0] id, logic expHit);
    @(negedge clk);
    sidValid = 1'b1; sidIn = id;
    @(negedge clk);
    sidValid = 1'b0;
    check(req, matchValid, 1'b1, "matchValid");
    check(req, matchHit, expHit, $sformatf("matchHit id=%h", id));
  endtask

  task automatic testReset();  // R1
    check("R1", matchValid, 1'b0, "matchValid after reset");
    check("R1", matchHit, 1'b0, "matchHit after reset");
    probe("R1", 32'h0000_0000, 1'b1);
    probe("R1", 32'hDEAD_BEEF, 1'b1);
  endtask

  task automatic testValid();  // R2
    @(negedge clk);
    sidValid = 1'b0; sidIn = 32'h1234_5678;
    @(negedge clk);
    check("R2", matchValid, 1'b0, "matchValid idle");
    check("R2", matchHit, 1'b0, "matchHit idle");
  endtask

  task automatic testExact();  // R3
    writeCfg(1'b1, 32'h0000_0000);
    writeCfg(1'b0, 32'h0000_0042);
    probe("R3", 32'h0000_0042, 1'b1);
    probe("R3", 32'h0000_0043, 1'b0);
    probe("R3", 32'h8000_0042, 1'b0);
  endtask

  task automatic testSpan();  // R4
    writeCfg(1'b1, 32'h2000_0000);
    writeCfg(1'b0, 32'h0000_0042);
    probe("R4", 32'h0000_0042, 1'b1);
    probe("R4", 32'h0000_0043, 1'b1);
    probe("R4", 32'h0000_0040, 1'b0);
    probe("R4", 32'h0000_0041, 1'b0);
    probe("R4", 32'h0000_0044, 1'b0);
    writeCfg(1'b0, 32'h1234_5677);
    probe("R4", 32'h1234_5670, model(mPat, mSpan, 32'h1234_5670));
    probe("R4", 32'h1234_566F, model(mPat, mSpan, 32'h1234_566F));
  endtask

  task automatic testBitZero();  // R5
    writeCfg(1'b0, 32'hFFFF_FFFE);
    probe("R5", 32'hFFFF_FFFF, 1'b1);
    probe("R5", 32'hFFFF_FFFD, 1'b0);
  endtask

  task automatic testOpen();  // R6
    writeCfg(1'b0, 32'h7FFF_FFFF);
    probe("R6", 32'h0000_0000, 1'b1);
    writeCfg(1'b0, 32'hFFFF_FFFF);
    probe("R6", 32'h5555_AAAA, 1'b1);
  endtask

  task automatic testCfgPort();  // R7
    writeCfg(1'b0, 32'h0000_0042);
    writeCfg(1'b1, 32'hDFFF_FFFF);   // mode bit clear, all else set
    probe("R7", 32'h0000_0043, 1'b0);
    probe("R7", 32'h0000_0042, 1'b1);
    @(negedge clk);
    cfgWrEn = 1'b0; cfgSel = 1'b0; cfgData = 32'h0000_0001;
    @(negedge clk);
    cfgSel = 1'b1; cfgData = 32'h2000_0000;
    @(negedge clk);
    probe("R7", 32'h0000_0042, 1'b1);
    probe("R7", 32'h0000_0001, 1'b0);
  endtask

  task automatic testOrder();  // R8
    writeCfg(1'b1, 32'h2000_0000);
    writeCfg(1'b0, 32'h0000_0042);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b0; cfgData = 32'h0000_0080;
    sidValid = 1'b1; sidIn = 32'h0000_0043;
    @(negedge clk);
    cfgWrEn = 1'b0; sidValid = 1'b0; mPat = 32'h0000_0080;
    check("R8", matchHit, 1'b1, "same-cycle id uses old pattern");
    probe("R8", 32'h0000_0043, 1'b0);
    probe("R8", 32'h0000_0081, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testValid();
    testExact();
    testSpan();
    testBitZero();
    testOpen();
    testCfgPort();
    testOrder();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule